// File: doc/BRIEF.md
# Operand Specifier Parser

This block turns a little-endian stream of bytes into one decoded operand at a time. The first byte of every operand is a format byte. Its upper three bits pick a mode and its lower five bits carry a size or register number. Depending on the mode, zero to nine further bytes follow: register numbers, a scale byte, or immediate and displacement bytes. When the last byte of an operand has been taken, the block presents a registered operand record. The record holds the kind, the value, and for memory operands the base and index register numbers, the scale, the sign-extended displacement, the access length and the computed effective address.

Register contents come through a single combinational read port. Every register number the stream names is driven on that port as its byte arrives, and the legality flags returned with it are checked at once. Malformed input raises a one-cycle exception pulse with a code. The block then stops taking bytes until the next reset. Operands can follow each other back to back, and the stream may stall between any two bytes.

Top module: `opnd_parse`

## Requirements
- R1: The format byte splits into mode = bits 7:5 and sub = bits 4:0. Mode 0 is a register operand. It yields kind 0, a value equal to the contents of register sub, and sub in the base field.
- R2: Mode 7 is an immediate of sub bytes (1, 2, 4 or 8). The bytes are assembled little-endian and zero-extended. The kind is 1, 2, 3 or 4 for 8, 16, 32 or 64 bits.
- R3: A mode 7 format byte whose sub is not 1, 2, 4 or 8 raises exception code 1 (illegal).
- R4: Modes 1 to 6 are memory operands of kind 5, with sub as the access length. A sub other than 1, 2, 4 or 8 raises code 1.
- R5: Mode 1 reads one base byte. Its index is 0, scale 0 and displacement 0, so the address is the base register's contents.
- R6: Mode 2 reads a base byte and then an index byte, with scale 1 and displacement 0. The address is reg(base) + reg(index).
- R7: Mode 3 reads base and index, then a 2-byte displacement sign-extended to 64 bits. Mode 4 does the same with a 4-byte displacement. Both use scale 1.
- R8: Mode 5 reads base, index, an unsigned scale byte and four displacement bytes. The displacement is the low 16 bits of those bytes, sign-extended. The address is reg(base) + reg(index) × scale + displacement.
- R9: Mode 6 reads base and an 8-byte displacement. Its index field is the always-zero register number (parameter ZERO_REG), which adds nothing, and its scale is 1.
- R10: Each register number is checked as its byte arrives, with this priority. A number at or above NREG gives code 1. A register flagged reserved gives code 2 (access). A register flagged system-only while user_mode is high gives code 3 (system).
- R11: out_valid pulses for exactly one cycle, in the cycle after the last byte of an operand is accepted. Idle cycles between bytes are allowed, and a new format byte may follow at once.
- R12: exc_valid pulses one cycle after the offending byte is accepted. From then on in_ready stays low and no record is issued until reset.
- R13: After reset, in_ready is high and out_valid and exc_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte is valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| user_mode | input | 1 | Current privilege is user |
| rd_idx | output | 8 | Register number on the read port |
| rd_val | input | 64 | Contents of register rd_idx |
| rd_reserved | input | 1 | Register rd_idx is reserved |
| rd_sysonly | input | 1 | Register rd_idx is system-only |
| out_valid | output | 1 | Operand record valid (one cycle) |
| out_kind | output | 3 | 0 reg, 1..4 imm 8/16/32/64, 5 memory |
| out_value | output | 64 | Register contents or immediate |
| out_base | output | 8 | Base register (register number for kind 0) |
| out_index | output | 8 | Index register |
| out_scale | output | 8 | Index scale |
| out_disp | output | 64 | Sign-extended displacement |
| out_mlen | output | 5 | Memory access length in bytes |
| out_ea | output | 64 | Effective address |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 1 illegal, 2 access, 3 system |

## Verification
The bench builds the block with NREG = 24 instead of the default 32. This lets the five-bit register field of a mode 0 byte name numbers past the end of the register file, so the out-of-range path of R10 can be reached from every register byte. ZERO_REG stays at 0, and the bench register file holds zero there, so the mode 6 index field can be compared with a known value. Random stalls, random privilege and random register flags exercise the acceptance timing and the fault priority.

// File: rtl/opnd_pkg.sv
`timescale 1ns/1ps
package opnd_pkg;
  localparam int XLEN  = 64;
  localparam int BW    = 8;
  localparam int CNT_W = 4;

  typedef enum logic [2:0] {
    K_REG = 3'd0, K_IMM8 = 3'd1, K_IMM16 = 3'd2, K_IMM32 = 3'd3,
    K_IMM64 = 3'd4, K_MEM = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    X_NONE = 2'd0, X_ILL = 2'd1, X_ACC = 2'd2, X_SYS = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    S_FMT, S_BASE, S_INDEX, S_SCALE, S_DATA, S_HALT
  } st_e;

  typedef enum logic [1:0] {D_ZERO, D_S16, D_S32, D_FULL} dext_e;

  typedef struct packed {
    kind_e            kind;
    logic             legal;
    logic             has_index;
    logic             has_scale;
    logic             zero_idx;
    logic [CNT_W-1:0] dlen;
    dext_e            dext;
    logic [BW-1:0]    scale_def;
    logic [4:0]       sub;
  } fmt_t;

  function automatic logic len_ok(input logic [4:0] n);
    return (n == 5'd1) || (n == 5'd2) || (n == 5'd4) || (n == 5'd8);
  endfunction
endpackage

// File: rtl/opnd_fmt_dec.sv
`timescale 1ns/1ps
module opnd_fmt_dec
  import opnd_pkg::*;
(
  input  logic [BW-1:0] fmt,
  output fmt_t          dec
);
  logic [2:0] mode;
  logic [4:0] sub;
  assign mode = fmt[7:5];
  assign sub  = fmt[4:0];

  always_comb begin
    dec       = '0;
    dec.sub   = sub;
    dec.kind  = K_REG;
    dec.legal = 1'b1;
    dec.dext  = D_ZERO;
    case (mode)
      3'd0: ;
      3'd7: begin
        dec.legal = len_ok(sub);
        dec.dlen  = sub[CNT_W-1:0];
        dec.dext  = D_FULL;
        case (sub)
          5'd1:    dec.kind = K_IMM8;
          5'd2:    dec.kind = K_IMM16;
          5'd4:    dec.kind = K_IMM32;
          default: dec.kind = K_IMM64;
        endcase
      end
      default: begin
        dec.kind      = K_MEM;
        dec.legal     = len_ok(sub);
        dec.scale_def = BW'(1);
        case (mode)
          3'd1: dec.scale_def = '0;
          3'd2: dec.has_index = 1'b1;
          3'd3: begin
            dec.has_index = 1'b1;
            dec.dlen      = CNT_W'(2);
            dec.dext      = D_S16;
          end
          3'd4: begin
            dec.has_index = 1'b1;
            dec.dlen      = CNT_W'(4);
            dec.dext      = D_S32;
          end
          3'd5: begin
            dec.has_index = 1'b1;
            dec.has_scale = 1'b1;
            dec.dlen      = CNT_W'(4);
            dec.dext      = D_S16;
          end
          default: begin
            dec.zero_idx = 1'b1;
            dec.dlen     = CNT_W'(8);
            dec.dext     = D_FULL;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opnd_reg_chk.sv
`timescale 1ns/1ps
module opnd_reg_chk
  import opnd_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic [BW-1:0] idx,
  input  logic          reserved,
  input  logic          sysonly,
  input  logic          user,
  output exc_e          code
);
  always_comb begin
    if (32'(idx) >= NREG)        code = X_ILL;
    else if (reserved)           code = X_ACC;
    else if (sysonly && user)    code = X_SYS;
    else                         code = X_NONE;
  end
endmodule

// File: rtl/opnd_le_acc.sv
`timescale 1ns/1ps
module opnd_le_acc #(
  parameter int W  = 64,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int PW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] pos,
  input  logic [BW-1:0] din,
  output logic [W-1:0]  acc_n,
  output logic [W-1:0]  acc_q
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign acc_n[g*BW +: BW] = clr ? '0 :
                               (we && pos == PW'(g)) ? din : acc_q[g*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_n;
  end
endmodule

// File: rtl/opnd_ea_calc.sv
`timescale 1ns/1ps
module opnd_ea_calc
  import opnd_pkg::*;
(
  input  logic [XLEN-1:0] base_v,
  input  logic [XLEN-1:0] idx_v,
  input  logic [BW-1:0]   scale,
  input  logic [XLEN-1:0] raw,
  input  dext_e           dext,
  output logic [XLEN-1:0] disp,
  output logic [XLEN-1:0] ea
);
  always_comb begin
    case (dext)
      D_S16:   disp = {{(XLEN-16){raw[15]}}, raw[15:0]};
      D_S32:   disp = {{(XLEN-32){raw[31]}}, raw[31:0]};
      D_FULL:  disp = raw;
      default: disp = '0;
    endcase
    ea = base_v + idx_v * XLEN'(scale) + disp;
  end
endmodule

// File: rtl/opnd_parse.sv
`timescale 1ns/1ps
module opnd_parse
  import opnd_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int ZERO_REG = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  input  logic            user_mode,
  output logic [7:0]      rd_idx,
  input  logic [63:0]     rd_val,
  input  logic            rd_reserved,
  input  logic            rd_sysonly,
  output logic            out_valid,
  output logic [2:0]      out_kind,
  output logic [63:0]     out_value,
  output logic [7:0]      out_base,
  output logic [7:0]      out_index,
  output logic [7:0]      out_scale,
  output logic [63:0]     out_disp,
  output logic [4:0]      out_mlen,
  output logic [63:0]     out_ea,
  output logic            exc_valid,
  output logic [1:0]      exc_code
);
  localparam int PW = $clog2(XLEN / BW);

  st_e              st, st_n;
  fmt_t             dec_n, dec_q;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    base_num_q, idx_num_q, scale_q;
  logic [XLEN-1:0]  base_v_q, idx_v_q;
  logic             accept, fin, raise, mem_fin;
  exc_e             chk_code, rcode;
  logic [XLEN-1:0]  acc_n, acc_q;
  logic [XLEN-1:0]  base_v_e, idx_v_e, raw_e, disp_e, ea_e;
  logic [BW-1:0]    base_n_e, idx_n_e, scale_e;

  assign in_ready = (st != S_HALT);
  assign accept   = in_valid && in_ready;
  assign rd_idx   = (st == S_FMT) ? {3'b000, in_data[4:0]} : in_data;

  opnd_fmt_dec u_dec (.fmt(in_data), .dec(dec_n));

  opnd_reg_chk #(.NREG(NREG)) u_chk (
    .idx(rd_idx), .reserved(rd_reserved), .sysonly(rd_sysonly),
    .user(user_mode), .code(chk_code)
  );

  opnd_le_acc #(.W(XLEN), .BW(BW)) u_acc (
    .clk(clk), .rst(rst),
    .clr(accept && st == S_FMT),
    .we(accept && st == S_DATA),
    .pos(cnt[PW-1:0]), .din(in_data),
    .acc_n(acc_n), .acc_q(acc_q)
  );

  // Values seen by the final byte: fields arriving this cycle bypass their registers
  always_comb begin
    base_v_e = (st == S_BASE) ? rd_val  : base_v_q;
    base_n_e = (st == S_BASE) ? in_data : base_num_q;
    if (st == S_INDEX) begin
      idx_v_e = rd_val;
      idx_n_e = in_data;
    end else if (dec_q.has_index) begin
      idx_v_e = idx_v_q;
      idx_n_e = idx_num_q;
    end else begin
      idx_v_e = '0;
      idx_n_e = dec_q.zero_idx ? BW'(ZERO_REG) : '0;
    end
    scale_e = dec_q.has_scale ? scale_q : dec_q.scale_def;
    raw_e   = (st == S_DATA) ? acc_n : '0;
  end

  opnd_ea_calc u_ea (
    .base_v(base_v_e), .idx_v(idx_v_e), .scale(scale_e),
    .raw(raw_e), .dext(dec_q.dext), .disp(disp_e), .ea(ea_e)
  );

  always_comb begin
    fin   = 1'b0;
    raise = 1'b0;
    rcode = X_NONE;
    st_n  = st;
    if (accept) begin
      case (st)
        S_FMT: begin
          if (!dec_n.legal) begin
            raise = 1'b1;
            rcode = X_ILL;
          end else if (dec_n.kind == K_REG) begin
            if (chk_code != X_NONE) begin
              raise = 1'b1;
              rcode = chk_code;
            end else fin = 1'b1;
          end else if (dec_n.kind == K_MEM) st_n = S_BASE;
          else st_n = S_DATA;
        end
        S_BASE, S_INDEX: begin
          if (chk_code != X_NONE) begin
            raise = 1'b1;
            rcode = chk_code;
          end else if (st == S_BASE && dec_q.has_index) st_n = S_INDEX;
          else if (st == S_INDEX && dec_q.has_scale)    st_n = S_SCALE;
          else if (dec_q.dlen == '0)                    fin  = 1'b1;
          else                                          st_n = S_DATA;
        end
        S_SCALE: st_n = S_DATA;
        S_DATA:  if (cnt == dec_q.dlen - CNT_W'(1)) fin = 1'b1;
        default: ;
      endcase
    end
    if (raise)    st_n = S_HALT;
    else if (fin) st_n = S_FMT;
  end

  assign mem_fin = (st != S_FMT) && (dec_q.kind == K_MEM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_FMT;
      dec_q      <= '0;
      cnt        <= '0;
      base_num_q <= '0;
      idx_num_q  <= '0;
      scale_q    <= '0;
      base_v_q   <= '0;
      idx_v_q    <= '0;
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_value  <= '0;
      out_base   <= '0;
      out_index  <= '0;
      out_scale  <= '0;
      out_disp   <= '0;
      out_mlen   <= '0;
      out_ea     <= '0;
      exc_valid  <= 1'b0;
      exc_code   <= '0;
    end else begin
      st        <= st_n;
      out_valid <= fin;
      exc_valid <= raise;
      if (raise) exc_code <= rcode;
      if (accept) begin
        case (st)
          S_FMT: begin
            dec_q <= dec_n;
            cnt   <= '0;
          end
          S_BASE: begin
            base_num_q <= in_data;
            base_v_q   <= rd_val;
          end
          S_INDEX: begin
            idx_num_q <= in_data;
            idx_v_q   <= rd_val;
          end
          S_SCALE: scale_q <= in_data;
          S_DATA:  cnt     <= cnt + CNT_W'(1);
          default: ;
        endcase
      end
      if (fin) begin
        out_kind  <= (st == S_FMT) ? K_REG : dec_q.kind;
        out_value <= (st == S_FMT) ? rd_val : (mem_fin ? '0 : acc_n);
        out_base  <= (st == S_FMT) ? {3'b000, in_data[4:0]} : (mem_fin ? base_n_e : '0);
        out_index <= mem_fin ? idx_n_e : '0;
        out_scale <= mem_fin ? scale_e : '0;
        out_disp  <= mem_fin ? disp_e  : '0;
        out_mlen  <= mem_fin ? dec_q.sub : '0;
        out_ea    <= mem_fin ? ea_e    : '0;
      end
    end
  end

  // R12: once an exception is signalled the stream is closed
  a_r12_halt_closes: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !in_ready);
  // R12: no record follows an exception
  a_r12_no_record_after: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !out_valid);
  // R11: a record always follows an accepted byte by one cycle
  a_r11_record_after_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));
  // R11: record and exception never coincide
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && exc_valid));
  // R4: a memory record carries a legal access length
  a_r4_mlen_legal: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == K_MEM) |->
      (out_mlen == 5'd1 || out_mlen == 5'd2 || out_mlen == 5'd4 || out_mlen == 5'd8));
  // R10: an exception always carries a nonzero code
  a_r10_code_set: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> exc_code != X_NONE);
endmodule

// File: tb/sim_opnd_parse.sv
`timescale 1ns/1ps
module sim_opnd_parse;
  localparam int NREG = 24;
  localparam int ZREG = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        user_mode = 1'b0;
  logic [7:0]  rd_idx;
  logic [63:0] rd_val;
  logic        rd_reserved, rd_sysonly;
  logic        out_valid, exc_valid;
  logic [2:0]  out_kind;
  logic [63:0] out_value, out_disp, out_ea;
  logic [7:0]  out_base, out_index, out_scale;
  logic [4:0]  out_mlen;
  logic [1:0]  exc_code;

  logic [63:0] rf [NREG];
  bit          resv [NREG];
  bit          sysf [NREG];

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign rd_val      = (32'(rd_idx) < NREG) ? rf[rd_idx[4:0]] : '0;
  assign rd_reserved = (32'(rd_idx) < NREG) ? resv[rd_idx[4:0]] : 1'b0;
  assign rd_sysonly  = (32'(rd_idx) < NREG) ? sysf[rd_idx[4:0]] : 1'b0;

  opnd_parse #(.NREG(NREG), .ZERO_REG(ZREG)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .user_mode(user_mode), .rd_idx(rd_idx),
    .rd_val(rd_val), .rd_reserved(rd_reserved), .rd_sysonly(rd_sysonly),
    .out_valid(out_valid), .out_kind(out_kind), .out_value(out_value),
    .out_base(out_base), .out_index(out_index), .out_scale(out_scale),
    .out_disp(out_disp), .out_mlen(out_mlen), .out_ea(out_ea),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] q[$];
  bit         m_halt = 0;
  bit         e_done = 0, e_exc = 0;
  int         e_code, e_kind, e_base, e_idx, e_scale, e_mlen;
  logic [63:0] e_val, e_disp, e_ea;
  string      e_tag;

  int p_st, p_code, p_kind, p_base, p_idx, p_scale, p_mlen;
  logic [63:0] p_val, p_disp, p_ea;
  string p_tag;

  function automatic int chkreg(input int r);
    if (r >= NREG) return 1;
    if (resv[r]) return 2;
    if (sysf[r] && user_mode) return 3;
    return 0;
  endfunction

  function automatic bit lenok(input int n);
    return n == 1 || n == 2 || n == 4 || n == 8;
  endfunction

  task automatic eval_q();
    int mode, sub, c, need;
    logic [63:0] raw, bv, iv;
    mode = int'(q[0][7:5]);
    sub  = int'(q[0][4:0]);
    p_st = 0; p_val = 0; p_disp = 0; p_ea = 0;
    p_base = 0; p_idx = 0; p_scale = 0; p_mlen = 0; p_kind = 0;
    if (mode == 0) begin
      c = chkreg(sub);
      if (c != 0) begin p_st = 2; p_code = c; p_tag = "R10"; end
      else begin p_st = 1; p_val = rf[sub]; p_base = sub; p_tag = "R1"; end
      return;
    end
    if (mode == 7) begin
      if (!lenok(sub)) begin p_st = 2; p_code = 1; p_tag = "R3"; return; end
      if (q.size() < 1 + sub) return;
      raw = 0;
      for (int k = 0; k < sub; k++) raw = raw | (64'(q[1+k]) << (8*k));
      p_kind = (sub == 1) ? 1 : (sub == 2) ? 2 : (sub == 4) ? 3 : 4;
      p_val = raw; p_st = 1; p_tag = "R2";
      return;
    end
    if (!lenok(sub)) begin p_st = 2; p_code = 1; p_tag = "R4"; return; end
    if (q.size() < 2) return;
    c = chkreg(int'(q[1]));
    if (c != 0) begin p_st = 2; p_code = c; p_tag = "R10"; return; end
    if (mode >= 2 && mode <= 5) begin
      if (q.size() < 3) return;
      c = chkreg(int'(q[2]));
      if (c != 0) begin p_st = 2; p_code = c; p_tag = "R10"; return; end
    end
    need = (mode == 1) ? 2 : (mode == 2) ? 3 : (mode == 3) ? 5 :
           (mode == 4) ? 7 : (mode == 5) ? 8 : 10;
    if (q.size() < need) return;
    p_base = int'(q[1]); bv = rf[p_base]; iv = 0; p_scale = 1;
    case (mode)
      1: begin p_scale = 0; p_tag = "R5"; end
      2: begin p_idx = int'(q[2]); iv = rf[p_idx]; p_tag = "R6"; end
      3: begin p_idx = int'(q[2]); iv = rf[p_idx];
               p_disp = 64'(longint'(shortint'({q[4], q[3]}))); p_tag = "R7"; end
      4: begin p_idx = int'(q[2]); iv = rf[p_idx];
               p_disp = 64'(longint'(int'({q[6], q[5], q[4], q[3]}))); p_tag = "R7"; end
      5: begin p_idx = int'(q[2]); iv = rf[p_idx]; p_scale = int'(q[3]);
               p_disp = 64'(longint'(shortint'({q[5], q[4]}))); p_tag = "R8"; end
      default: begin
        p_idx = ZREG; raw = 0;
        for (int k = 0; k < 8; k++) raw = raw | (64'(q[2+k]) << (8*k));
        p_disp = raw; p_tag = "R9";
      end
    endcase
    p_ea = bv + iv * 64'(p_scale) + p_disp;
    p_kind = 5; p_mlen = sub; p_st = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_halt <= 0; e_done <= 0; e_exc <= 0;
    end else begin
      e_done <= 0; e_exc <= 0;
      if (in_valid && !m_halt) begin
        q.push_back(in_data);
        eval_q();
        if (p_st == 1) begin
          e_done <= 1; e_kind <= p_kind; e_val <= p_val; e_base <= p_base;
          e_idx <= p_idx; e_scale <= p_scale; e_disp <= p_disp;
          e_mlen <= p_mlen; e_ea <= p_ea; e_tag <= p_tag;
          q.delete();
        end else if (p_st == 2) begin
          e_exc <= 1; e_code <= p_code; e_tag <= p_tag; m_halt <= 1;
          q.delete();
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(out_valid == e_done, "R11", "out_valid", 64'(out_valid), 64'(e_done));
      chk(exc_valid == e_exc, "R12", "exc_valid", 64'(exc_valid), 64'(e_exc));
      chk(in_ready == !m_halt, "R12", "in_ready", 64'(in_ready), 64'(!m_halt));
      if (e_done && out_valid) begin
        chk(int'(out_kind) == e_kind, e_tag, "kind", 64'(out_kind), 64'(e_kind));
        chk(out_value == e_val, e_tag, "value", out_value, e_val);
        chk(int'(out_base) == e_base, e_tag, "base", 64'(out_base), 64'(e_base));
        chk(int'(out_index) == e_idx, e_tag, "index", 64'(out_index), 64'(e_idx));
        chk(int'(out_scale) == e_scale, e_tag, "scale", 64'(out_scale), 64'(e_scale));
        chk(out_disp == e_disp, e_tag, "disp", out_disp, e_disp);
        chk(int'(out_mlen) == e_mlen, e_tag, "mlen", 64'(out_mlen), 64'(e_mlen));
        chk(out_ea == e_ea, e_tag, "ea", out_ea, e_ea);
      end
      if (e_exc && exc_valid)
        chk(int'(exc_code) == e_code, e_tag, "exc_code", 64'(exc_code), 64'(e_code));
    end
  end

  // ---------------- stimulus ----------------
  task automatic reset_dut();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R13: state right after reset
    chk(in_ready == 1'b1, "R13", "in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R13", "out_valid", 64'(out_valid), 64'd0);
    chk(exc_valid == 1'b0, "R13", "exc_valid", 64'(exc_valid), 64'd0);
  endtask

  task automatic send_op(input logic [7:0] b[$], input bit gaps);
    foreach (b[k]) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        in_valid = 1'b0; @(negedge clk);
      end
      if (m_halt) break;
      in_valid = 1'b1; in_data = b[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (m_halt) reset_dut();
  endtask

  function automatic logic [7:0] reg_byte();
    if ($urandom_range(0, 9) == 0) return 8'($urandom_range(0, 255));
    return 8'($urandom_range(0, NREG - 1));
  endfunction

  task automatic random_op();
    logic [7:0] b[$];
    int mode, sub, len, nreg;
    int lens[4] = '{1, 2, 4, 8};
    mode = $urandom_range(0, 7);
    if (mode == 0) sub = $urandom_range(0, 31);
    else if ($urandom_range(0, 7) == 0) sub = $urandom_range(0, 31);
    else sub = lens[$urandom_range(0, 3)];
    b.push_back({3'(mode), 5'(sub)});
    nreg = (mode >= 2 && mode <= 5) ? 2 : (mode == 1 || mode == 6) ? 1 : 0;
    if (mode == 0) len = 1;
    else if (!lenok(sub)) len = 1;
    else if (mode == 7) len = 1 + sub;
    else len = (mode == 1) ? 2 : (mode == 2) ? 3 : (mode == 3) ? 5 :
               (mode == 4) ? 7 : (mode == 5) ? 8 : 10;
    for (int k = 1; k < len; k++)
      b.push_back((k <= nreg) ? reg_byte() : 8'($urandom_range(0, 255)));
    send_op(b, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      rf[i] = {32'($urandom), 32'($urandom)};
      resv[i] = 0; sysf[i] = 0;
    end
    rf[ZREG] = '0;
    resv[20] = 1; sysf[21] = 1; sysf[22] = 1;
    rf[5] = 64'h0000_0000_0001_0000;
    rf[6] = 64'h0000_0000_0000_0100;
    reset_dut();
    // R1 register operand; R10 number past NREG
    send_op('{8'h03}, 1'b0);
    send_op('{8'h19}, 1'b0);
    // R2 immediates of each width, R3 bad width
    send_op('{8'hE1, 8'h9A}, 1'b0);
    send_op('{8'hE2, 8'h34, 8'h12}, 1'b1);
    send_op('{8'hE4, 8'h78, 8'h56, 8'h34, 8'h92}, 1'b0);
    send_op('{8'hE8, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'hF8}, 1'b1);
    send_op('{8'hE3, 8'h00}, 1'b0);
    // R5..R9 memory modes, R4 bad length
    send_op('{8'h24, 8'h05}, 1'b0);
    send_op('{8'h48, 8'h05, 8'h06}, 1'b0);
    send_op('{8'h62, 8'h05, 8'h06, 8'h00, 8'h80}, 1'b0);
    send_op('{8'h81, 8'h05, 8'h06, 8'hFE, 8'hFF, 8'hFF, 8'hFF}, 1'b1);
    send_op('{8'hA8, 8'h05, 8'h06, 8'h03, 8'h34, 8'h92, 8'h11, 8'h22}, 1'b0);
    send_op('{8'hC2, 8'h07, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80}, 1'b0);
    send_op('{8'h23, 8'h05}, 1'b0);
    // R10 reserved and system-only registers
    send_op('{8'h24, 8'd20}, 1'b0);
    user_mode = 1'b1;
    send_op('{8'h48, 8'h05, 8'd21}, 1'b0);
    user_mode = 1'b0;
    send_op('{8'h48, 8'h05, 8'd21}, 1'b0);
    send_op('{8'h30, 8'h05}, 1'b0);
    // R11 back-to-back and stalled random traffic
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 7) == 0) user_mode = 1'($urandom_range(0, 1));
      random_op();
    end
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule